// File: doc/BRIEF.md
# Stack-to-Register Rename Front End

This block sits between instruction decode and the issue logic of a core that executes a stack instruction set on a flat physical register file. It keeps a virtual operand stack in which every entry is a physical register tag, not a data value. Each decoded stack operation pops source tags from that stack and, when it produces a value, takes a fresh destination tag from a free-tag FIFO. It emits a renamed micro-operation one cycle later. Swap and rotate are carried out by permuting tags in the mapping stack, so they move no data and issue nothing.

Tags come back to the free FIFO through a release port. The surrounding core drives that port once the last reader of a tag has issued. Because every produced value gets its own physical tag, two nearby operations that read different stack positions carry no false dependency. Operations that have already issued keep writing to the tags they were given, whatever shuffles follow. The front end stalls its input with a ready signal when a tag is needed and none is free, or when a push would overflow the stack. An operation that needs more stack entries than are present is consumed, flagged as an underflow, and leaves all state unchanged.

Top module: `tagstack_rename`

## Requirements
- R1: After reset the mapping stack is empty, `in_ready` is 1, `uop_valid` and `underflow` are 0, and the free FIFO holds every tag in ascending order, so the first three pushes receive destination tags 0, 1 and 2. A micro-op appears on the outputs in the cycle after its operation is accepted (`in_valid` and `in_ready` both 1 at a clock edge).
- R2: Push (operation code 1) emits a micro-op with `uop_dst_used`=1, `uop_dst` equal to the head of the free FIFO, and both source flags 0. That tag becomes the new top of the mapping stack.
- R3: Binary (code 4) emits `uop_src0` = top tag and `uop_src1` = the tag below it, both flagged used, and a fresh `uop_dst`. The two sources are removed and the destination tag becomes the new top, so the depth drops by one.
- R4: Unary (code 3) emits `uop_src0` = top tag and a fresh `uop_dst`, and the destination tag replaces the top entry.
- R5: Drop (code 2) emits `uop_src0` = top tag with no destination (`uop_dst_used`=0) and removes the top entry.
- R6: Swap (code 5) exchanges the two top tags, emits no micro-op, takes no tag from the free FIFO, and is accepted even when the stack is full or no tag is free.
- R7: Rotate (code 6) moves the third tag to the top, the old top to second and the old second to third. It emits no micro-op and takes no tag.
- R8: An operation whose required entry count exceeds the current depth is accepted, raises `underflow` for one cycle in the next cycle, emits no micro-op and changes neither the stack nor the free FIFO. The counts are 1 for drop and unary, 2 for binary and swap, and 3 for rotate.
- R9: When the free FIFO is empty, `in_ready` is 0 for push, unary and binary that are not underflowing, and stays 1 for the other codes.
- R10: When the stack holds its full depth (16 by default), `in_ready` is 0 for push.
- R11: A tag named on `rel_tag` while `rel_valid` is 1 joins the tail of the free FIFO at that clock edge, whether or not the input operation is accepted. A release and an allocation may occur in the same cycle. A tag released while the FIFO is empty can be allocated in the next cycle.
- R12: Code 0 (no-op) and code 7 are accepted, emit nothing and change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | A decoded stack operation is present |
| in_op | input | 3 | Operation code (see R2 to R12) |
| in_ready | output | 1 | Operation can be accepted this cycle |
| rel_valid | input | 1 | A tag is being returned to the free FIFO |
| rel_tag | input | TAG_W (5) | Tag being returned |
| uop_valid | output | 1 | Renamed micro-op present |
| uop_src0 | output | TAG_W (5) | First source tag (old top) |
| uop_src0_used | output | 1 | First source tag is meaningful |
| uop_src1 | output | TAG_W (5) | Second source tag (entry below top) |
| uop_src1_used | output | 1 | Second source tag is meaningful |
| uop_dst | output | TAG_W (5) | Destination tag |
| uop_dst_used | output | 1 | Destination tag is meaningful |
| underflow | output | 1 | One-cycle flag for a consumed underflowing operation |

## Verification
The free FIFO can be read by an allocation and written by a release in the same cycle, and the interesting moments are when it holds one tag or none. The bench drains the FIFO with unary operations on a full stack. It then releases a dead tag in the same cycle as a stalled unary, and later in the same cycle as an accepted one. It judges the outcome by which tag the following allocations receive and by when `in_ready` rises again. A reference model built from the requirements predicts every output across all operation codes at stack depths 0 to 3, and over a long pseudo-random mix.

// File: rtl/tr_pkg.sv
package tr_pkg;

    typedef enum logic [2:0] {
        OP_NOP    = 3'd0,
        OP_PUSH   = 3'd1,
        OP_DROP   = 3'd2,
        OP_UNARY  = 3'd3,
        OP_BINARY = 3'd4,
        OP_SWAP   = 3'd5,
        OP_ROT    = 3'd6
    } stk_op_e;

    typedef struct packed {
        logic [1:0] reads;   // entries the operation needs on the stack
        logic       alloc;   // takes a destination tag
        logic       grows;   // net depth increase of one
        logic       emits;   // produces a micro-op
    } op_info_t;

    function automatic op_info_t decode_op(input logic [2:0] code);
        op_info_t r;
        r = '0;
        case (code)
            OP_PUSH:   begin r.alloc = 1'b1; r.grows = 1'b1; r.emits = 1'b1; end
            OP_DROP:   begin r.reads = 2'd1; r.emits = 1'b1; end
            OP_UNARY:  begin r.reads = 2'd1; r.alloc = 1'b1; r.emits = 1'b1; end
            OP_BINARY: begin r.reads = 2'd2; r.alloc = 1'b1; r.emits = 1'b1; end
            OP_SWAP:   r.reads = 2'd2;
            OP_ROT:    r.reads = 2'd3;
            default:   r = '0;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/tr_free_fifo.sv
module tr_free_fifo #(
    parameter int NUM_TAGS = 32,
    parameter int TAG_W    = $clog2(NUM_TAGS),
    localparam int PTR_W   = $clog2(NUM_TAGS),
    localparam int CNT_W   = $clog2(NUM_TAGS + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             take,
    input  logic             give,
    input  logic [TAG_W-1:0] give_tag,
    output logic [TAG_W-1:0] head,
    output logic             empty
);
    logic [TAG_W-1:0] pool [NUM_TAGS];
    logic [PTR_W-1:0] rd_ptr, wr_ptr;
    logic [CNT_W-1:0] cnt;
    logic             do_give, do_take;

    function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(NUM_TAGS - 1)) ? '0 : p + PTR_W'(1);
    endfunction

    assign empty   = (cnt == '0);
    assign head    = pool[rd_ptr];
    assign do_take = take && !empty;
    assign do_give = give && ((cnt != CNT_W'(NUM_TAGS)) || do_take);

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NUM_TAGS; i++) pool[i] <= TAG_W'(i);
            rd_ptr <= '0;
            wr_ptr <= '0;
            cnt    <= CNT_W'(NUM_TAGS);
        end else begin
            if (do_take) rd_ptr <= bump(rd_ptr);
            if (do_give) begin
                pool[wr_ptr] <= give_tag;
                wr_ptr       <= bump(wr_ptr);
            end
            case ({do_give, do_take})
                2'b10:   cnt <= cnt + CNT_W'(1);
                2'b01:   cnt <= cnt - CNT_W'(1);
                default: cnt <= cnt;
            endcase
        end
    end
endmodule

// File: rtl/tr_map_stack.sv
module tr_map_stack
    import tr_pkg::*;
#(
    parameter int DEPTH  = 16,
    parameter int TAG_W  = 5,
    localparam int CNT_W = $clog2(DEPTH + 1),
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  stk_op_e          op,
    input  logic [TAG_W-1:0] new_tag,
    output logic [CNT_W-1:0] depth,
    output logic [TAG_W-1:0] tag0,
    output logic [TAG_W-1:0] tag1
);
    logic [TAG_W-1:0] slot [DEPTH];
    logic [CNT_W-1:0] sp_q;
    logic [IDX_W-1:0] i_top, i_nxt, i_third, i_new;

    assign i_top   = IDX_W'(sp_q - CNT_W'(1));
    assign i_nxt   = IDX_W'(sp_q - CNT_W'(2));
    assign i_third = IDX_W'(sp_q - CNT_W'(3));
    assign i_new   = IDX_W'(sp_q);
    assign depth   = sp_q;
    assign tag0    = slot[i_top];
    assign tag1    = slot[i_nxt];

    always_ff @(posedge clk) begin
        if (rst) begin
            sp_q <= '0;
            for (int k = 0; k < DEPTH; k++) slot[k] <= '0;
        end else if (en) begin
            case (op)
                OP_PUSH: begin
                    slot[i_new] <= new_tag;
                    sp_q        <= sp_q + CNT_W'(1);
                end
                OP_DROP:  sp_q <= sp_q - CNT_W'(1);
                OP_UNARY: slot[i_top] <= new_tag;
                OP_BINARY: begin
                    slot[i_nxt] <= new_tag;
                    sp_q        <= sp_q - CNT_W'(1);
                end
                OP_SWAP: begin
                    slot[i_top] <= slot[i_nxt];
                    slot[i_nxt] <= slot[i_top];
                end
                OP_ROT: begin
                    slot[i_top]   <= slot[i_third];
                    slot[i_nxt]   <= slot[i_top];
                    slot[i_third] <= slot[i_nxt];
                end
                default: sp_q <= sp_q;
            endcase
        end
    end
endmodule

// File: rtl/tagstack_rename.sv
module tagstack_rename
    import tr_pkg::*;
#(
    parameter int STACK_DEPTH = 16,
    parameter int NUM_TAGS    = 32,
    localparam int TAG_W      = $clog2(NUM_TAGS),
    localparam int CNT_W      = $clog2(STACK_DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    input  logic [2:0]       in_op,
    output logic             in_ready,
    input  logic             rel_valid,
    input  logic [TAG_W-1:0] rel_tag,
    output logic             uop_valid,
    output logic [TAG_W-1:0] uop_src0,
    output logic             uop_src0_used,
    output logic [TAG_W-1:0] uop_src1,
    output logic             uop_src1_used,
    output logic [TAG_W-1:0] uop_dst,
    output logic             uop_dst_used,
    output logic             underflow
);
    op_info_t         info;
    logic [CNT_W-1:0] depth;
    logic [TAG_W-1:0] top_tag, nxt_tag, fresh_tag;
    logic             fl_empty, short_stack, full, stall, fire, commit;

    assign info        = decode_op(in_op);
    assign short_stack = depth < CNT_W'(info.reads);
    assign full        = depth == CNT_W'(STACK_DEPTH);
    assign stall       = !short_stack &&
                         ((info.alloc && fl_empty) || (info.grows && full));
    assign in_ready    = !stall;
    assign fire        = in_valid && in_ready;
    assign commit      = fire && !short_stack;

    tr_free_fifo #(.NUM_TAGS(NUM_TAGS), .TAG_W(TAG_W)) u_free (
        .clk      (clk),
        .rst      (rst),
        .take     (commit && info.alloc),
        .give     (rel_valid),
        .give_tag (rel_tag),
        .head     (fresh_tag),
        .empty    (fl_empty)
    );

    tr_map_stack #(.DEPTH(STACK_DEPTH), .TAG_W(TAG_W)) u_map (
        .clk     (clk),
        .rst     (rst),
        .en      (commit),
        .op      (stk_op_e'(in_op)),
        .new_tag (fresh_tag),
        .depth   (depth),
        .tag0    (top_tag),
        .tag1    (nxt_tag)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            uop_valid     <= 1'b0;
            uop_src0      <= '0;
            uop_src0_used <= 1'b0;
            uop_src1      <= '0;
            uop_src1_used <= 1'b0;
            uop_dst       <= '0;
            uop_dst_used  <= 1'b0;
            underflow     <= 1'b0;
        end else begin
            uop_valid     <= commit && info.emits;
            uop_src0      <= top_tag;
            uop_src0_used <= commit && info.emits && (info.reads != 2'd0);
            uop_src1      <= nxt_tag;
            uop_src1_used <= commit && info.emits && (info.reads == 2'd2);
            uop_dst       <= fresh_tag;
            uop_dst_used  <= commit && info.alloc;
            underflow     <= fire && short_stack;
        end
    end
endmodule

// File: rtl/tr_rename_chk.sv
module tr_rename_chk #(
    parameter int TAG_W = 5
) (
    input logic             clk,
    input logic             rst,
    input logic             in_valid,
    input logic             in_ready,
    input logic             uop_valid,
    input logic [TAG_W-1:0] uop_src0,
    input logic             uop_src0_used,
    input logic [TAG_W-1:0] uop_src1,
    input logic             uop_src1_used,
    input logic [TAG_W-1:0] uop_dst,
    input logic             uop_dst_used,
    input logic             underflow
);
    AST_UOP_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (rst)
        uop_valid |-> $past(in_valid && in_ready)); // R1
    AST_PUSH_HAS_DST: assert property (@(posedge clk) disable iff (rst)
        (uop_valid && !uop_src0_used) |-> uop_dst_used); // R2
    AST_SRC_PAIR_DISTINCT: assert property (@(posedge clk) disable iff (rst)
        (uop_valid && uop_src1_used) |-> (uop_src0_used && uop_src0 != uop_src1)); // R3
    AST_DST_NOT_LIVE_SRC: assert property (@(posedge clk) disable iff (rst)
        (uop_valid && uop_dst_used && uop_src0_used) |-> (uop_dst != uop_src0)); // R4
    AST_UNDERFLOW_SILENT: assert property (@(posedge clk) disable iff (rst)
        underflow |-> !uop_valid); // R8
    AST_UNDERFLOW_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (rst)
        underflow |-> $past(in_valid && in_ready)); // R8
endmodule

bind tagstack_rename tr_rename_chk #(.TAG_W(TAG_W)) u_chk (
    .clk           (clk),
    .rst           (rst),
    .in_valid      (in_valid),
    .in_ready      (in_ready),
    .uop_valid     (uop_valid),
    .uop_src0      (uop_src0),
    .uop_src0_used (uop_src0_used),
    .uop_src1      (uop_src1),
    .uop_src1_used (uop_src1_used),
    .uop_dst       (uop_dst),
    .uop_dst_used  (uop_dst_used),
    .underflow     (underflow)
);

// File: tb/sim_tagstack_rename.sv
module sim_tagstack_rename;
    localparam int CLK_PERIOD  = 10;
    localparam int STACK_DEPTH = 16;
    localparam int NUM_TAGS    = 32;
    localparam int TAG_W       = $clog2(NUM_TAGS);

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             in_valid = 1'b0;
    logic [2:0]       in_op = 3'd0;
    logic             in_ready;
    logic             rel_valid = 1'b0;
    logic [TAG_W-1:0] rel_tag = '0;
    logic             uop_valid, uop_src0_used, uop_src1_used, uop_dst_used, underflow;
    logic [TAG_W-1:0] uop_src0, uop_src1, uop_dst;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;
    int model[$];
    int fq[$];
    int dead[$];

    always #(CLK_PERIOD / 2) clk = ~clk;

    tagstack_rename #(.STACK_DEPTH(STACK_DEPTH), .NUM_TAGS(NUM_TAGS)) u0 (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_op(in_op), .in_ready(in_ready),
        .rel_valid(rel_valid), .rel_tag(rel_tag), .uop_valid(uop_valid),
        .uop_src0(uop_src0), .uop_src0_used(uop_src0_used), .uop_src1(uop_src1),
        .uop_src1_used(uop_src1_used), .uop_dst(uop_dst), .uop_dst_used(uop_dst_used),
        .underflow(underflow)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic int reads_of(input int code);
        case (code)
            2, 3:    return 1;
            4, 5:    return 2;
            6:       return 3;
            default: return 0;
        endcase
    endfunction

    function automatic string req_of(input int code);
        case (code)
            1: return "R2";
            2: return "R5";
            3: return "R4";
            4: return "R3";
            5: return "R6";
            6: return "R7";
            default: return "R12";
        endcase
    endfunction

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; in_valid = 1'b0; rel_valid = 1'b0; in_op = 3'd0;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        model.delete(); fq.delete(); dead.delete();
        for (int i = 0; i < NUM_TAGS; i++) fq.push_back(i);
    endtask

    task automatic idle();
        @(negedge clk);
        in_valid = 1'b0; rel_valid = 1'b0; in_op = 3'd0;
    endtask

    task automatic step(input int code, input bit rv, input int rt, input string tag);
        int rd, e0, e1, ed, a, b, c;
        bit al, em, gr, sh, rdy;
        string rq, rrq;
        rd = reads_of(code);
        al = (code == 1 || code == 3 || code == 4);
        em = (code >= 1 && code <= 4);
        gr = (code == 1);
        sh = (model.size() < rd);
        rdy = sh || !((al && fq.size() == 0) || (gr && model.size() == STACK_DEPTH));
        rq = (tag != "") ? tag : (sh ? "R8" : req_of(code));
        rrq = rdy ? rq : ((al && fq.size() == 0) ? "R9" : "R10");
        e0 = -1; e1 = -1; ed = -1;
        @(negedge clk);
        in_valid = 1'b1; in_op = 3'(code); rel_valid = rv; rel_tag = TAG_W'(rt);
        #1;
        chk(rrq, "in_ready", int'(in_ready), int'(rdy));
        if (rdy && !sh) begin
            case (code)
                1: begin ed = fq.pop_front(); model.push_back(ed); end
                2: begin e0 = model.pop_back(); dead.push_back(e0); end
                3: begin
                    e0 = model[$]; ed = fq.pop_front(); model[$] = ed; dead.push_back(e0);
                end
                4: begin
                    e0 = model.pop_back(); e1 = model[$]; ed = fq.pop_front();
                    model[$] = ed; dead.push_back(e0); dead.push_back(e1);
                end
                5: begin
                    a = model[$]; model[$] = model[$-1]; model[$-1] = a;
                end
                6: begin
                    a = model[$]; b = model[$-1]; c = model[$-2];
                    model[$] = c; model[$-1] = a; model[$-2] = b;
                end
                default: ;
            endcase
        end
        if (rv) fq.push_back(rt);
        @(posedge clk);
        #(CLK_PERIOD / 4);
        chk(rq, "uop_valid", int'(uop_valid), int'(rdy && !sh && em));
        chk(sh ? "R8" : rq, "underflow", int'(underflow), int'(rdy && sh));
        if (rdy && !sh && em) begin
            chk(rq, "src0_used", int'(uop_src0_used), int'(e0 >= 0));
            chk(rq, "src1_used", int'(uop_src1_used), int'(e1 >= 0));
            chk(rq, "dst_used", int'(uop_dst_used), int'(ed >= 0));
            if (e0 >= 0) chk(rq, "src0", int'(uop_src0), e0);
            if (e1 >= 0) chk(rq, "src1", int'(uop_src1), e1);
            if (ed >= 0) chk(rq, "dst", int'(uop_dst), ed);
        end
    endtask

    task automatic drain();
        while (model.size() > 0) step(2, 1'b0, 0, "");
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        logic [15:0] lf;
        int r, t;
        // R1: reset state and first allocations
        do_reset();
        #1;
        chk("R1", "in_ready", int'(in_ready), 1);
        chk("R1", "uop_valid", int'(uop_valid), 0);
        chk("R1", "underflow", int'(underflow), 0);
        for (int i = 0; i < 3; i++) step(1, 1'b0, 0, "R1");

        // sweep every code at depths 0..3, then drain to observe state (R8, R12)
        for (int d = 0; d < 4; d++) begin
            for (int code = 0; code < 8; code++) begin
                do_reset();
                for (int k = 0; k < d; k++) step(1, 1'b0, 0, "");
                step(code, 1'b0, 0, "");
                drain();
                idle();
            end
        end

        // R10: full stack blocks push, swap still goes (R6)
        do_reset();
        for (int k = 0; k < STACK_DEPTH; k++) step(1, 1'b0, 0, "");
        step(1, 1'b0, 0, "R10");
        step(5, 1'b0, 0, "R6");

        // R9: exhaust the free FIFO with unary operations
        for (int k = 0; k < NUM_TAGS - STACK_DEPTH; k++) step(3, 1'b0, 0, "");
        step(3, 1'b0, 0, "R9");
        step(5, 1'b0, 0, "R9");
        step(6, 1'b0, 0, "R9");
        // R11: release during a stalled allocation, then allocate it
        t = dead.pop_front();
        step(3, 1'b1, t, "R11");
        step(3, 1'b0, 0, "R11");
        // R11: one tag free, allocate and release in the same cycle
        t = dead.pop_front();
        step(0, 1'b1, t, "R11");
        t = dead.pop_front();
        step(3, 1'b1, t, "R11");
        step(3, 1'b0, 0, "R11");
        step(3, 1'b0, 0, "R9");
        drain();
        idle();

        // mixed pseudo-random sequence against the model
        do_reset();
        lf = 16'hACE1;
        for (int n = 0; n < 800; n++) begin
            lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
            r = int'(lf);
            if (dead.size() > 0 && ((r >> 5) & 1) == 1) begin
                t = dead.pop_front();
                step(((r >> 3) & 1) == 1 ? 1 : (r & 7), 1'b1, t, "");
            end else begin
                step(((r >> 3) & 1) == 1 ? 1 : (r & 7), 1'b0, 0, "");
            end
        end
        drain();
        idle();

        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule